// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block times the pulse train coming from a fan's tachometer output. It passes the raw signal through a flop synchronizer and counts system clock cycles from one rising edge to the next. Each finished interval is written to a read-only measurement register, and a one-cycle new-measurement pulse goes out with it. One interval covers one tach pulse. A fan that gives 1, 2 or 4 pulses per turn therefore yields a count for a fraction of a turn, and converting it to speed is left to software.

Software loads an expected period and a tolerance through a simple register port. Each new measurement is compared against the inclusive window from expected minus tolerance to expected plus tolerance. A reading outside the window raises a one-cycle tach-error pulse in the same cycle as the new-measurement pulse. If the fan stops and the counter reaches its ceiling, the block reports the ceiling value and flags an error. It then waits for a fresh edge before it starts timing again. In the interrupt word of the surrounding controller, the new-measurement pulse feeds bit 3 and the tach-error pulse feeds bit 1.

Top module: `fan_tach_monitor`

## Requirements
- R1: A measurement equals the number of clock cycles between two successive synchronized rising edges of `tach_i`. It appears on `meas_o` and reads back at address 0xC4.
- R2: Each completed measurement drives `new_meas_o` high for exactly one cycle, in the same cycle that `meas_o` takes the new value.
- R3: The first rising edge after reset, or after a saturation report, starts the count and produces no measurement.
- R4: When the expected period is nonzero, `tach_err_o` pulses together with `new_meas_o` exactly when the measurement is below expected minus tolerance or above expected plus tolerance. Both bounds are inclusive.
- R5: While the expected period is zero, no measurement raises `tach_err_o`.
- R6: The lower bound is clamped at zero when the tolerance is at least the expected period. The upper bound is computed one bit wider than the counter, so it never wraps.
- R7: If no edge arrives before the counter reaches its all-ones ceiling, `meas_o` takes the ceiling value and `new_meas_o` and `tach_err_o` pulse together. No further report occurs until the counter is armed by a new edge.
- R8: After reset, `meas_o`, the expected period and the tolerance are zero, and both pulse outputs are low.
- R9: A write to address 0x88 loads the expected period and a write to 0x8C loads the tolerance; both read back at their addresses. A write to 0xC4 has no effect. Reads of any other address return zero.
- R10: The shortest tach period, one cycle high and one cycle low, is measured as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_i | input | 1 | Raw tachometer signal from the fan |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for reads and writes |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data for `reg_addr_i` |
| meas_o | output | CNT_W | Last measured period in clock cycles |
| new_meas_o | output | 1 | One-cycle pulse on each completed measurement |
| tach_err_o | output | 1 | One-cycle pulse when a measurement is out of window or saturated |

## Verification
Periodic tach waveforms are driven at several periods against a range of window settings. The cases include periods one cycle inside and one cycle outside each bound, which separates inclusive from exclusive comparisons. Further cases use a disabled window, a tolerance larger than the expected period, and an expected period near the counter ceiling, which expose underflow and wrap in the bound arithmetic. A period of two cycles shows whether the edge detector and counter restart lose a cycle. A stalled fan, held high after one edge, shows three things: that arming produces no report, that saturation reports once with an error, and that the block stays silent afterwards.

// File: rtl/fan_tach_pkg.sv
`timescale 1ns/1ps
package fan_tach_pkg;
  localparam logic [7:0] ADDR_EXPECT = 8'h88;
  localparam logic [7:0] ADDR_TOLER  = 8'h8C;
  localparam logic [7:0] ADDR_MEAS   = 8'hC4;
endpackage

// File: rtl/tach_sync_rise.sv
`timescale 1ns/1ps
module tach_sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_i,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = {sync_q[0], tach_i};
    end else begin : g_many
      always_comb sync_d = {sync_q[LAST-1:0], tach_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rise_o = sync_q[LAST-1] & ~sync_q[LAST];

  // R1
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tach_window_chk.sv
`timescale 1ns/1ps
module tach_window_chk #(
  parameter int CNT_W = 20
) (
  input  logic [CNT_W-1:0] meas_i,
  input  logic [CNT_W-1:0] expect_i,
  input  logic [CNT_W-1:0] toler_i,
  output logic             out_win_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] hi_bound;
  logic [EXT_W-1:0] lo_bound;
  logic [EXT_W-1:0] meas_ext;
  logic             enabled;

  always_comb begin
    meas_ext = {1'b0, meas_i};
    hi_bound = {1'b0, expect_i} + {1'b0, toler_i};
    if (toler_i >= expect_i) lo_bound = '0;
    else                     lo_bound = {1'b0, expect_i} - {1'b0, toler_i};
    enabled   = (expect_i != '0);
    out_win_o = enabled && ((meas_ext > hi_bound) || (meas_ext < lo_bound));
  end
endmodule

// File: rtl/tach_period_counter.sv
`timescale 1ns/1ps
module tach_period_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             out_win_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             new_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             meas_en;
  logic             new_d, err_d;
  logic             new_q, err_q;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    meas_d  = meas_q;
    meas_en = 1'b0;
    new_d   = 1'b0;
    err_d   = 1'b0;
    if (rise_i) begin
      if (armed_q) begin
        meas_d  = cnt_q;
        meas_en = 1'b1;
        new_d   = 1'b1;
        err_d   = out_win_i;
      end
      armed_d = 1'b1;
      cnt_d   = CNT_ONE;
    end else if (armed_q) begin
      if (cnt_q == CNT_MAX) begin
        meas_d  = CNT_MAX;
        meas_en = 1'b1;
        new_d   = 1'b1;
        err_d   = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      new_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      new_q   <= new_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       meas_q <= '0;
    else if (meas_en) meas_q <= meas_d;
  end

  assign cnt_o  = cnt_q;
  assign meas_o = meas_q;
  assign new_o  = new_q;
  assign err_o  = err_q;

  // R3
  first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !armed_q) |=> !new_q);
  // R4
  err_with_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> new_q);
  // R1
  meas_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    new_q |-> (meas_q != '0));
  // R7
  sat_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !rise_i && cnt_q == CNT_MAX) |=> (!armed_q && err_q && meas_q == CNT_MAX));
endmodule

// File: rtl/fan_tach_monitor.sv
`timescale 1ns/1ps
module fan_tach_monitor
  import fan_tach_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tach_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  meas_o,
  output logic              new_meas_o,
  output logic              tach_err_o
);
  localparam logic [ADDR_W-1:0] A_EXP  = ADDR_W'(ADDR_EXPECT);
  localparam logic [ADDR_W-1:0] A_TOL  = ADDR_W'(ADDR_TOLER);
  localparam logic [ADDR_W-1:0] A_MEAS = ADDR_W'(ADDR_MEAS);

  logic             rise;
  logic             out_win;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] expect_q, toler_q;
  logic             exp_en, tol_en;

  always_comb begin
    exp_en = reg_wr_i && (reg_addr_i == A_EXP);
    tol_en = reg_wr_i && (reg_addr_i == A_TOL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      expect_q <= '0;
    else if (exp_en) expect_q <= reg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      toler_q <= '0;
    else if (tol_en) toler_q <= reg_wdata_i;
  end

  always_comb begin
    case (reg_addr_i)
      A_EXP:   reg_rdata_o = expect_q;
      A_TOL:   reg_rdata_o = toler_q;
      A_MEAS:  reg_rdata_o = meas_o;
      default: reg_rdata_o = '0;
    endcase
  end

  tach_sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  tach_window_chk #(.CNT_W(CNT_W)) u_win (
    .meas_i    (cnt),
    .expect_i  (expect_q),
    .toler_i   (toler_q),
    .out_win_o (out_win)
  );

  tach_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .out_win_i (out_win),
    .cnt_o     (cnt),
    .meas_o    (meas_o),
    .new_o     (new_meas_o),
    .err_o     (tach_err_o)
  );

  // R9
  exp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_en |=> (expect_q == $past(reg_wdata_i)));
  // R5
  disabled_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && expect_q == '0 && cnt != '1) |=> !tach_err_o);
endmodule

// File: tb/fan_tach_monitor_test.sv
`timescale 1ns/1ps
module fan_tach_monitor_test;
  localparam int CW  = 12;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tach = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = 8'h00;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic [CW-1:0] meas;
  logic          new_meas, terr;

  int checks = 0;
  int failures = 0;
  int ev_cnt = 0;
  int last_meas = 0;
  int last_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fan_tach_monitor #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .tach_i(tach), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .meas_o(meas), .new_meas_o(new_meas), .tach_err_o(terr)
  );

  always @(negedge clk) begin
    if (new_meas) begin
      ev_cnt    = ev_cnt + 1;
      last_meas = int'(meas);
      last_err  = int'(terr);
    end
  end

  // period, expected, tolerance, expected error
  localparam int NV = 10;
  localparam int VEC [NV][4] = '{
    '{40,   0,    0,   0},  // R5 window disabled
    '{40,   40,   0,   0},  // R4 exact match
    '{50,   40,   10,  0},  // R4 upper bound inclusive
    '{51,   40,   10,  1},  // R4 above upper bound
    '{30,   40,   10,  0},  // R4 lower bound inclusive
    '{29,   40,   10,  1},  // R4 below lower bound
    '{100,  20,   30,  1},  // R6 clamped low, above high
    '{10,   20,   30,  0},  // R6 no underflow
    '{7,    4000, 200, 1},  // R6 upper bound wider than counter
    '{2,    0,    0,   0}   // R10 shortest period
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input int d);
    addr = a; wdata = CW'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic tach_cycles(input int p, input int n);
    for (int k = 0; k < n; k++) begin
      tach = 1'b1;
      repeat (p / 2) @(negedge clk);
      tach = 1'b0;
      repeat (p - p / 2) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures = failures + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(meas == '0, "R8 meas", int'(meas), 0);
    check(!new_meas && !terr, "R8 pulses", int'({new_meas, terr}), 0);
    reg_read(8'h88, rv); check(rv == 0, "R8 expected reg", rv, 0);
    reg_read(8'h8C, rv); check(rv == 0, "R8 tolerance reg", rv, 0);

    // R3 first edge only arms
    tach = 1'b1;
    repeat (100) @(negedge clk);
    check(ev_cnt == 0, "R3 first edge", ev_cnt, 0);

    // R7 stalled fan saturates once
    repeat (4200) @(negedge clk);
    check(ev_cnt == 1, "R7 sat events", ev_cnt, 1);
    check(last_meas == MAXV, "R7 sat value", last_meas, MAXV);
    check(last_err == 1, "R7 sat error", last_err, 1);
    repeat (5000) @(negedge clk);
    check(ev_cnt == 1, "R7 stays disarmed", ev_cnt, 1);

    // R9 read-only measurement, unmapped reads
    reg_write(8'hC4, 123);
    reg_read(8'hC4, rv); check(rv == MAXV, "R9 meas read-only", rv, MAXV);
    reg_read(8'h00, rv); check(rv == 0, "R9 unmapped read", rv, 0);
    reg_write(8'h88, 77);
    reg_read(8'h88, rv); check(rv == 77, "R9 expected readback", rv, 77);
    tach = 1'b0;
    @(negedge clk);

    // table walk: R1 R2 R4 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      int base;
      reg_write(8'h88, VEC[i][1]);
      reg_write(8'h8C, VEC[i][2]);
      tach_cycles(VEC[i][0], 3);
      repeat (6) @(negedge clk);
      base = ev_cnt;
      tach_cycles(VEC[i][0], 3);
      repeat (6) @(negedge clk);
      check(last_meas == VEC[i][0], "R1 period", last_meas, VEC[i][0]);
      check(last_err == VEC[i][3], "R4 error flag", last_err, VEC[i][3]);
      check(ev_cnt - base == 3, "R2 one pulse per period", ev_cnt - base, 3);
      reg_read(8'hC4, rv);
      check(rv == VEC[i][0], "R1 register read", rv, VEC[i][0]);
    end

    finish_run();
  end
endmodule